// File: doc/BRIEF.md
# Lockstep Comparator with Retry Classification

This block sits beside a pair of processors that execute the same instruction stream in lockstep. Every clock cycle it compares what the two cores drive onto their output buses, together with each core's valid strobe. When the two disagree, it asks the memory side to discard the transaction in flight. While the fault budget is not used up, it also asks the element to run the failed operation again.

Disagreements are counted until a transaction commits. A fault that clears on retry allows a commit, and the commit resets the count, so the fault is treated as transient. A fault that keeps recurring drives the count up to a parameterised limit. At that point the whole processing element is isolated, together with a last rollback so another element can take over the work. The element never continues on one core. Isolation stays latched until reset, and while isolated the block issues no further requests.

Top module: `lockstep_guard`

## Requirements
- R1: When both valid strobes are high in a cycle and the two buses differ, that cycle is a mismatch. The cycle after it, rollback_o is high for one cycle.
- R2: When exactly one valid strobe is high in a cycle, that cycle is a mismatch, whatever the bus contents.
- R3: A cycle with both strobes high and equal buses, or with both strobes low, is not a mismatch. Both strobes low counts as no mismatch even when the buses differ. In the following cycle rollback_o and retry_o are low.
- R4: A mismatch that leaves the count below RETRY_LIMIT raises retry_o and rollback_o together, for the one cycle after the mismatch.
- R5: The count rises by one per mismatch and is cleared only by a commit. The mismatch that brings it to RETRY_LIMIT (default 3) raises isolate_o and rollback_o in the next cycle, with retry_o low.
- R6: Once isolate_o is high, it stays high until rst_ni is asserted. A commit does not clear it.
- R7: In every cycle after the one in which isolate_o rises, rollback_o and retry_o are low, even if mismatches continue.
- R8: A commit_i pulse in a cycle without a mismatch clears the count. If commit_i arrives in the same cycle as a mismatch, the mismatch is counted and the commit has no effect.
- R9: While rst_ni is low, rollback_o, retry_o and isolate_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_valid_i | input | 1 | Core A bus valid |
| a_bus_i | input | BUS_W | Core A output bus |
| b_valid_i | input | 1 | Core B bus valid |
| b_bus_i | input | BUS_W | Core B output bus |
| commit_i | input | 1 | Transaction committed |
| rollback_o | output | 1 | Request rollback of the in-flight transaction |
| retry_o | output | 1 | Request re-execution on this element |
| isolate_o | output | 1 | Element isolated (latched) |

## Verification
The bench first drives matching traffic, and idle cycles with differing bus contents, to confirm that neither raises a request. It then drives data mismatches in a single lane and mismatches caused only by the valid strobes; these show that both kinds of disagreement are detected. Runs of mismatches with and without commits between them show that a transient fault, cleared by a commit, differs from a persistent one that reaches isolation. Traffic driven after isolation, and a commit in the same cycle as a mismatch, cover the latching and the priority rule.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef struct packed {
    logic rollback;
    logic retry;
    logic isolate;
  } req_t;
endpackage

// File: rtl/ls_compare.sv
module ls_compare #(
  parameter int BUS_W = 32,
  parameter int LANES = 4
) (
  input  logic             a_valid_i,
  input  logic [BUS_W-1:0] a_bus_i,
  input  logic             b_valid_i,
  input  logic [BUS_W-1:0] b_bus_i,
  output logic             mismatch_o
);
  localparam int LaneW = BUS_W / LANES;

  logic [LANES-1:0] lane_neq;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_neq[l] = a_bus_i[l*LaneW +: LaneW] != b_bus_i[l*LaneW +: LaneW];
  end

  // strobe disagreement always counts; data only when both drive
  always_comb begin
    mismatch_o = (a_valid_i ^ b_valid_i) | (a_valid_i & b_valid_i & (|lane_neq));
  end

  initial begin
    lanes_div_chk: assert (BUS_W % LANES == 0);
  end
endmodule

// File: rtl/ls_retry_ctrl.sv
module ls_retry_ctrl
  import lockstep_pkg::*;
#(
  parameter int RETRY_LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mismatch_i,
  input  logic commit_i,
  output req_t req_o
);
  localparam int CntW = $clog2(RETRY_LIMIT + 1);

  logic [CntW-1:0] cnt_q, cnt_inc;
  req_t            req_q;

  assign cnt_inc = cnt_q + CntW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= '0;
    end else if (req_q.isolate) begin
      req_q.rollback <= 1'b0;
      req_q.retry    <= 1'b0;
    end else if (mismatch_i) begin
      cnt_q          <= cnt_inc;
      req_q.rollback <= 1'b1;
      if (cnt_inc >= CntW'(RETRY_LIMIT)) begin
        req_q.isolate <= 1'b1;
        req_q.retry   <= 1'b0;
      end else begin
        req_q.retry   <= 1'b1;
      end
    end else begin
      req_q.rollback <= 1'b0;
      req_q.retry    <= 1'b0;
      if (commit_i) cnt_q <= '0;
    end
  end

  assign req_o = req_q;

  // R1
  mismatch_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_i && !req_q.isolate) |=> req_q.rollback);
  // R4
  retry_has_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.retry |-> req_q.rollback);
  // R5
  retry_not_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_q.retry && req_q.isolate));
  // R6
  isolate_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.isolate |=> req_q.isolate);
  // R7
  isolate_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.isolate |=> (!req_q.rollback && !req_q.retry));
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
  import lockstep_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int LANES       = 4,
  parameter int RETRY_LIMIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_valid_i,
  input  logic [BUS_W-1:0] a_bus_i,
  input  logic             b_valid_i,
  input  logic [BUS_W-1:0] b_bus_i,
  input  logic             commit_i,
  output logic             rollback_o,
  output logic             retry_o,
  output logic             isolate_o
);
  logic mismatch;
  req_t req;

  ls_compare #(.BUS_W(BUS_W), .LANES(LANES)) u_cmp (
    .a_valid_i (a_valid_i),
    .a_bus_i   (a_bus_i),
    .b_valid_i (b_valid_i),
    .b_bus_i   (b_bus_i),
    .mismatch_o(mismatch)
  );

  ls_retry_ctrl #(.RETRY_LIMIT(RETRY_LIMIT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mismatch_i(mismatch),
    .commit_i  (commit_i),
    .req_o     (req)
  );

  assign rollback_o = req.rollback;
  assign retry_o    = req.retry;
  assign isolate_o  = req.isolate;

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!rollback_o && !retry_o && !isolate_o));
endmodule

// File: tb/sim_lockstep_guard.sv
module sim_lockstep_guard;
  localparam int W = 32;
  localparam int LIMIT = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic a_v = 1'b0, b_v = 1'b0, commit = 1'b0;
  logic [W-1:0] a_b = '0, b_b = '0;
  logic rb, rt, iso;

  typedef struct {
    logic  rb;
    logic  rt;
    logic  iso;
    string tag;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  int m_cnt = 0;
  bit m_iso = 0;

  always #5 clk = ~clk;

  lockstep_guard #(.BUS_W(W), .LANES(4), .RETRY_LIMIT(LIMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_valid_i(a_v), .a_bus_i(a_b), .b_valid_i(b_v), .b_bus_i(b_b),
    .commit_i(commit), .rollback_o(rb), .retry_o(rt), .isolate_o(iso)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: {rollback,retry,isolate} actual=%b expected=%b", tag, act, ex);
    end
  endtask

  // driver: apply one cycle of stimulus, push model prediction
  task automatic drive(input logic av, input logic [W-1:0] ab, input logic bv,
                       input logic [W-1:0] bb, input logic cm, input string tag);
    exp_t e;
    logic mis;
    @(negedge clk);
    a_v = av; a_b = ab; b_v = bv; b_b = bb; commit = cm;
    mis = (av != bv) || (av && bv && ab != bb);
    e.tag = tag;
    if (m_iso) begin
      e.rb = 0; e.rt = 0; e.iso = 1;
    end else if (mis) begin
      m_cnt++;
      e.rb = 1;
      if (m_cnt >= LIMIT) begin m_iso = 1; e.rt = 0; e.iso = 1; end
      else begin e.rt = 1; e.iso = 0; end
    end else begin
      e.rb = 0; e.rt = 0; e.iso = 0;
      if (cm) m_cnt = 0;
    end
    q.push_back(e);
  endtask

  task automatic good(input logic cm, input string tag);
    drive(1, 32'hCAFE_0001, 1, 32'hCAFE_0001, cm, tag);
  endtask
  task automatic bad(input logic cm, input string tag);
    drive(1, 32'h0000_1234, 1, 32'h0000_1235, cm, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; a_v = 0; b_v = 0; commit = 0;
    m_cnt = 0; m_iso = 0;
    #1 chk("R9 reset", {rb, rt, iso}, 3'b000);
    @(negedge clk);
    rst_ni = 1;
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, {rb, rt, iso}, {e.rb, e.rt, e.iso});
      end
    end
  end

  initial begin
    #1 chk("R9 reset", {rb, rt, iso}, 3'b000);
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    good(0, "R3 equal");
    good(1, "R3 equal commit");
    drive(0, 32'h1111_1111, 0, 32'h2222_2222, 0, "R3 idle differing");
    bad(0, "R1 R4 data mismatch");
    good(0, "R3 after mismatch");
    drive(1, 32'h5, 0, 32'h5, 0, "R2 only A valid");
    good(1, "R8 commit clears");
    drive(0, 32'h5, 1, 32'h5, 0, "R2 only B valid");
    drive(1, 32'hFF00_0000, 1, 32'h0F00_0000, 0, "R1 R4 top lane");
    good(1, "R8 commit clears");
    bad(0, "R4 first");
    good(0, "R5 no commit between");
    bad(0, "R4 second");
    good(0, "R5 no commit");
    bad(0, "R5 third isolates");
    bad(0, "R7 quiet while isolated");
    drive(1, 32'h1, 0, 32'h1, 0, "R7 quiet valid mismatch");
    good(1, "R6 commit no clear");
    good(0, "R6 held");
    repeat (3) @(negedge clk);
    do_reset();
    bad(0, "R4 after reset");
    bad(1, "R8 commit with mismatch");
    bad(0, "R5 isolate after same-cycle commit");
    good(0, "R6 held");
    repeat (3) @(negedge clk);
    do_reset();
    bad(0, "R4 run1");
    bad(0, "R4 run2");
    bad(0, "R5 run3");
    good(1, "R7 R6 after");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule